// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block arbitrates a parameterised set of interrupt request lines for a small processor core. Each line carries four pieces of state: an enable bit, a pending bit, an active bit and a programmable priority. A rising edge on a request line latches that line as pending. The block then offers the core the most urgent pending, enabled line whose priority can pre-empt the work now running. The offer consists of a take strobe and the line number. The core accepts with an acknowledge and later signals a return. A separate non-maskable input outranks every maskable line.

Software drives a small command port. A command sets or clears an enable bit, sets or clears a pending bit, or writes a priority. The enable, pending and active vectors are always visible on read outputs. Accepted interrupts are held on an internal return stack. This lets a return retire the most recently accepted interrupt, so nested pre-emption unwinds in the right order. The current execution level is the most urgent priority among the active lines.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable, pending and active bit is 0, every priority is 0, `take_o` is 0, `nmi_active_o` is 0 and `cur_idle_o` is 1.
- R2: `reg_op_i` codes act on line `reg_idx_i` at the next clock edge. The codes are 1 = enable set, 2 = enable clear, 3 = pending set, 4 = pending clear and 5 = priority write from `reg_wdata_i`. Code 0 does nothing. The result shows on `enable_o` and `pending_o` after that edge.
- R3: A 0-to-1 change on `irq_i[n]` sets pending bit n whether or not line n is enabled. A request held high does not set the bit again after software clears it.
- R4: A pending line whose enable bit is 0 is never offered. Setting its enable bit makes it eligible.
- R5: Among eligible lines, the one offered has the lowest numeric priority, and a tie goes to the lower line number. `take_o` and `take_id_o` are registered and reflect the state present one clock edge earlier.
- R6: An `ack_i` sampled while `take_o` is high (and `ret_i` is low) makes the offered line active and clears its pending bit. `take_o` is low after that edge.
- R7: While any line is active, a maskable line is offered only if its priority value is strictly below the current level. An equal or larger value waits.
- R8: Several lines may be active at once (pre-empted lines stay active). `cur_prio_o` is the smallest priority value among active lines. With no line active, `cur_idle_o` is 1 and `cur_prio_o` is all ones.
- R9: A `ret_i` clears the active bit of the most recently accepted interrupt that has not yet returned.
- R10: If an eligible line is pending when a return is taken, `take_o` is high again after the very next clock edge.
- R11: A rising edge on `nmi_i` makes a non-maskable request that is offered ahead of all lines, with `take_nmi_o` = 1. While it is active (`nmi_active_o`), no maskable line is offered. Its return clears `nmi_active_o`.
- R12: No software command alters any active bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_IRQ | Maskable request lines, edge detected |
| nmi_i | input | 1 | Non-maskable request, edge detected |
| reg_op_i | input | 3 | Software command code |
| reg_idx_i | input | IDX_W | Line addressed by the command |
| reg_wdata_i | input | PRIO_W | Priority value for the write command |
| ack_i | input | 1 | Core accepts the offered request |
| ret_i | input | 1 | Core returns from the current handler |
| take_o | output | 1 | A request is offered to the core |
| take_id_o | output | IDX_W | Number of the offered line |
| take_nmi_o | output | 1 | The offered request is the non-maskable one |
| enable_o | output | NUM_IRQ | Enable bits |
| pending_o | output | NUM_IRQ | Pending bits |
| active_o | output | NUM_IRQ | Active bits |
| nmi_active_o | output | 1 | Non-maskable handler running |
| cur_prio_o | output | PRIO_W | Current execution level |
| cur_idle_o | output | 1 | No interrupt is active |

## Verification
The bench sweeps every pair of lines over every pair of priority values. This separates a wrong comparison direction, wrong tie handling and any bias by line number. A hand-built nesting sequence uses equal, larger and smaller priorities against a running handler, which separates strict from non-strict pre-emption. The same sequence unwinds with returns, showing that retirement follows acceptance order and that a waiting request is offered right after a return. Separate patterns cover a request held high across a software clear, a disabled pending line, a non-maskable request arriving over a running handler, and software commands aimed at an active line.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_EN_SET   = 3'd1,
    OP_EN_CLR   = 3'd2,
    OP_PEND_SET = 3'd3,
    OP_PEND_CLR = 3'd4,
    OP_PRIO_WR  = 3'd5
  } reg_op_e;
endpackage

// File: rtl/pic_level.sv
module pic_level #(
  parameter int N  = 8,
  parameter int PW = 3
) (
  input  logic [N-1:0]         active,
  input  logic [N-1:0][PW-1:0] prio,
  output logic [PW-1:0]        level,
  output logic                 idle
);
  always_comb begin
    level = '1;
    idle  = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (active[i] && (idle || prio[i] < level)) begin
        level = prio[i];
        idle  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int N  = 8,
  parameter int PW = 3,
  localparam int IW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         pend,
  input  logic [N-1:0]         en,
  input  logic [N-1:0][PW-1:0] prio,
  input  logic [PW-1:0]        level,
  input  logic                 idle,
  input  logic                 block,
  output logic                 valid,
  output logic [IW-1:0]        idx
);
  logic [PW-1:0] best;

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && en[i] && !block && (idle || prio[i] < level) &&
          (!valid || prio[i] < best)) begin
        valid = 1'b1;
        idx   = IW'(i);
        best  = prio[i];
      end
    end
  end

  assert_winner_eligible_R5: assert property (@(posedge clk) disable iff (rst)
    valid |-> (pend[idx] && en[idx] && !block));
  assert_winner_preempts_R7: assert property (@(posedge clk) disable iff (rst)
    valid |-> (idle || prio[idx] < level));
endmodule

// File: rtl/pic_stack.sv
module pic_stack #(
  parameter int DEPTH = 9,
  parameter int EW    = 4,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [EW-1:0] din,
  output logic [EW-1:0] top,
  output logic          empty
);
  logic [EW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (push) mem[sp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (push) sp_q <= sp_q + 1'b1;
    else if (pop)  sp_q <= sp_q - 1'b1;
  end

  assign empty = (sp_q == '0);
  assign top   = empty ? '0 : mem[sp_q - 1'b1];

  assert_stack_bound_R9: assert property (@(posedge clk) disable iff (rst)
    !(push && sp_q == SPW'(DEPTH)));
  assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int DEPTH  = NUM_IRQ + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               nmi_i,
  input  logic [2:0]         reg_op_i,
  input  logic [IDX_W-1:0]   reg_idx_i,
  input  logic [PRIO_W-1:0]  reg_wdata_i,
  input  logic               ack_i,
  input  logic               ret_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   take_id_o,
  output logic               take_nmi_o,
  output logic [NUM_IRQ-1:0] enable_o,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic [NUM_IRQ-1:0] active_o,
  output logic               nmi_active_o,
  output logic [PRIO_W-1:0]  cur_prio_o,
  output logic               cur_idle_o
);
  import pic_pkg::*;

  logic [NUM_IRQ-1:0]             en_q, pend_q, act_q, irq_prev;
  logic [NUM_IRQ-1:0]             en_n, pend_n, act_n;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q, prio_n;
  logic nmi_prev, nmi_pend_q, nmi_act_q, nmi_pend_n, nmi_act_n;
  logic take_q, take_nmi_q;
  logic [IDX_W-1:0] take_id_q;

  reg_op_e          op_s;
  logic             ack_eff, ret_eff, stk_empty, nmi_cand, arb_valid;
  logic [IDX_W:0]   stk_top, stk_din;
  logic [IDX_W-1:0] arb_idx;
  logic [PRIO_W-1:0] level;
  logic             idle;

  assign op_s    = reg_op_e'(reg_op_i);
  assign ack_eff = ack_i && take_q && !ret_i;
  assign ret_eff = ret_i && !stk_empty;
  assign stk_din = {take_nmi_q, take_id_q};
  assign nmi_cand = nmi_pend_q && !nmi_act_q;

  pic_level #(.N(NUM_IRQ), .PW(PRIO_W)) level_i (
    .active(act_q), .prio(prio_q), .level(level), .idle(idle));

  pic_arb #(.N(NUM_IRQ), .PW(PRIO_W)) arb_i (
    .clk(clk), .rst(rst), .pend(pend_q), .en(en_q), .prio(prio_q),
    .level(level), .idle(idle), .block(nmi_act_q),
    .valid(arb_valid), .idx(arb_idx));

  pic_stack #(.DEPTH(DEPTH), .EW(IDX_W + 1)) stack_i (
    .clk(clk), .rst(rst), .push(ack_eff), .pop(ret_eff),
    .din(stk_din), .top(stk_top), .empty(stk_empty));

  always_comb begin
    en_n       = en_q;
    pend_n     = pend_q;
    act_n      = act_q;
    prio_n     = prio_q;
    nmi_pend_n = nmi_pend_q;
    nmi_act_n  = nmi_act_q;
    if (ack_eff) begin
      if (take_nmi_q) begin
        nmi_act_n  = 1'b1;
        nmi_pend_n = 1'b0;
      end else begin
        act_n[take_id_q]  = 1'b1;
        pend_n[take_id_q] = 1'b0;
      end
    end
    if (ret_eff) begin
      if (stk_top[IDX_W]) nmi_act_n = 1'b0;
      else                act_n[stk_top[IDX_W-1:0]] = 1'b0;
    end
    if (int'(reg_idx_i) < NUM_IRQ) begin
      case (op_s)
        OP_EN_SET:   en_n[reg_idx_i]   = 1'b1;
        OP_EN_CLR:   en_n[reg_idx_i]   = 1'b0;
        OP_PEND_SET: pend_n[reg_idx_i] = 1'b1;
        OP_PEND_CLR: pend_n[reg_idx_i] = 1'b0;
        OP_PRIO_WR:  prio_n[reg_idx_i] = reg_wdata_i;
        default: ;
      endcase
    end
    pend_n = pend_n | (irq_i & ~irq_prev);
    if (nmi_i && !nmi_prev) nmi_pend_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= '0;
      pend_q     <= '0;
      act_q      <= '0;
      prio_q     <= '0;
      irq_prev   <= '0;
      nmi_prev   <= 1'b0;
      nmi_pend_q <= 1'b0;
      nmi_act_q  <= 1'b0;
      take_q     <= 1'b0;
      take_id_q  <= '0;
      take_nmi_q <= 1'b0;
    end else begin
      en_q       <= en_n;
      pend_q     <= pend_n;
      act_q      <= act_n;
      prio_q     <= prio_n;
      irq_prev   <= irq_i;
      nmi_prev   <= nmi_i;
      nmi_pend_q <= nmi_pend_n;
      nmi_act_q  <= nmi_act_n;
      take_q     <= (nmi_cand || arb_valid) && !ack_eff && !ret_eff;
      take_id_q  <= arb_idx;
      take_nmi_q <= nmi_cand;
    end
  end

  assign take_o       = take_q;
  assign take_id_o    = take_id_q;
  assign take_nmi_o   = take_nmi_q;
  assign enable_o     = en_q;
  assign pending_o    = pend_q;
  assign active_o     = act_q;
  assign nmi_active_o = nmi_act_q;
  assign cur_prio_o   = level;
  assign cur_idle_o   = idle;

  assert_ack_sets_active_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_eff && !take_nmi_q) |=> act_q[$past(take_id_q)]);
  assert_ack_drops_take_R6: assert property (@(posedge clk) disable iff (rst)
    ack_eff |=> !take_q);
  assert_nmi_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    nmi_act_q |-> !take_q);
  assert_take_beats_level_R7: assert property (@(posedge clk) disable iff (rst)
    (take_q && !take_nmi_q && $past(reg_op_i) != 3'd5) |->
    (idle || prio_q[take_id_q] < level));
  assert_active_only_by_core_R12: assert property (@(posedge clk) disable iff (rst)
    (!ack_eff && !ret_eff) |=> $stable(act_q));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int PW = 3;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_i = '0;
  logic nmi_i = 1'b0;
  logic [2:0] reg_op_i = '0;
  logic [IW-1:0] reg_idx_i = '0;
  logic [PW-1:0] reg_wdata_i = '0;
  logic ack_i = 1'b0, ret_i = 1'b0;
  logic take_o, take_nmi_o, nmi_active_o, cur_idle_o;
  logic [IW-1:0] take_id_o;
  logic [N-1:0] enable_o, pending_o, active_o;
  logic [PW-1:0] cur_prio_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NUM_IRQ(N), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst(rst), .irq_i(irq_i), .nmi_i(nmi_i),
    .reg_op_i(reg_op_i), .reg_idx_i(reg_idx_i), .reg_wdata_i(reg_wdata_i),
    .ack_i(ack_i), .ret_i(ret_i), .take_o(take_o), .take_id_o(take_id_o),
    .take_nmi_o(take_nmi_o), .enable_o(enable_o), .pending_o(pending_o),
    .active_o(active_o), .nmi_active_o(nmi_active_o),
    .cur_prio_o(cur_prio_o), .cur_idle_o(cur_idle_o));

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op(input int code, input int idx, input int wd);
    reg_op_i = 3'(code); reg_idx_i = IW'(idx); reg_wdata_i = PW'(wd);
    tick();
    reg_op_i = '0;
  endtask

  task automatic ack_now;
    ack_i = 1'b1; tick(); ack_i = 1'b0;
  endtask

  task automatic ret_now;
    ret_i = 1'b1; tick(); ret_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk(take_o == 0 && enable_o == 0 && pending_o == 0 && active_o == 0 &&
        cur_idle_o == 1 && nmi_active_o == 0, "R1", int'(take_o), 0);
    rst = 1'b0;
    tick();

    // R2 software access
    op(1, 5, 0);
    chk(enable_o == 8'h20, "R2 enable set", int'(enable_o), 32);
    op(2, 5, 0);
    chk(enable_o == 8'h00, "R2 enable clear", int'(enable_o), 0);
    op(3, 6, 0);
    chk(pending_o == 8'h40, "R2 pending set", int'(pending_o), 64);
    op(4, 6, 0);
    chk(pending_o == 8'h00, "R2 pending clear", int'(pending_o), 0);

    // R3 edge latching, R4 enable gating
    irq_i[2] = 1'b1;
    tick();
    chk(pending_o == 8'h04, "R3 edge sets pending", int'(pending_o), 4);
    tick();
    chk(take_o == 0, "R4 disabled not offered", int'(take_o), 0);
    op(4, 2, 0);
    tick();
    chk(pending_o == 8'h00, "R3 held level no reset", int'(pending_o), 0);
    irq_i[2] = 1'b0;
    op(3, 2, 0);
    op(1, 2, 0);
    tick();
    chk(take_o == 1 && take_id_o == 2, "R4 enabled offered", int'(take_id_o), 2);
    op(4, 2, 0);
    for (int i = 0; i < N; i++) op(1, i, 0);

    // R5 exhaustive pairwise selection
    for (int a = 0; a < N - 1; a++)
      for (int b = a + 1; b < N; b++)
        for (int pa = 0; pa < 8; pa++)
          for (int pb = 0; pb < 8; pb++) begin
            op(5, a, pa);
            op(5, b, pb);
            op(3, a, 0);
            op(3, b, 0);
            tick();
            chk(take_o == 1 && int'(take_id_o) == ((pb < pa) ? b : a), "R5 select",
                int'(take_id_o), (pb < pa) ? b : a);
            op(4, a, 0);
            op(4, b, 0);
          end

    // Nesting scenario
    for (int i = 0; i < N; i++) op(5, i, 7);
    op(5, 1, 4); op(5, 2, 4); op(5, 3, 5); op(5, 4, 2);
    op(3, 1, 0);
    tick();
    chk(take_o == 1 && take_id_o == 1, "R5 single", int'(take_id_o), 1);
    ack_now();
    chk(active_o == 8'h02 && pending_o == 8'h00 && take_o == 0, "R6 accept",
        int'(active_o), 2);
    chk(cur_prio_o == 4 && cur_idle_o == 0, "R8 level one active", int'(cur_prio_o), 4);
    op(3, 2, 0);
    op(3, 3, 0);
    tick();
    chk(take_o == 0, "R7 equal or lower waits", int'(take_o), 0);
    op(3, 4, 0);
    tick();
    chk(take_o == 1 && take_id_o == 4, "R7 higher preempts", int'(take_id_o), 4);
    op(2, 1, 0);
    op(4, 1, 0);
    op(3, 1, 0);
    op(4, 1, 0);
    chk(active_o == 8'h02, "R12 sw cannot touch active", int'(active_o), 2);
    op(1, 1, 0);
    tick();
    chk(take_o == 1 && take_id_o == 4, "R12 offer intact", int'(take_id_o), 4);
    ack_now();
    chk(active_o == 8'h12 && cur_prio_o == 2, "R8 stacked active", int'(active_o), 18);
    ret_now();
    chk(active_o == 8'h02 && cur_prio_o == 4, "R9 return newest", int'(active_o), 2);
    tick();
    chk(take_o == 0, "R7 after return still blocked", int'(take_o), 0);
    ret_now();
    chk(active_o == 8'h00 && cur_idle_o == 1 && cur_prio_o == 7, "R8 idle",
        int'(cur_prio_o), 7);
    tick();
    chk(take_o == 1 && take_id_o == 2, "R10 tail chain", int'(take_id_o), 2);
    ack_now();
    ret_now();
    tick();
    chk(take_o == 1 && take_id_o == 3, "R10 tail chain second", int'(take_id_o), 3);
    ack_now();
    ret_now();
    tick();
    chk(take_o == 0 && pending_o == 8'h00, "R9 all retired", int'(pending_o), 0);

    // R11 non-maskable
    op(3, 1, 0);
    tick();
    ack_now();
    nmi_i = 1'b1;
    tick();
    tick();
    chk(take_o == 1 && take_nmi_o == 1, "R11 nmi offered", int'(take_nmi_o), 1);
    ack_now();
    chk(nmi_active_o == 1 && take_o == 0, "R11 nmi active", int'(nmi_active_o), 1);
    op(3, 4, 0);
    tick();
    tick();
    chk(take_o == 0, "R11 nmi blocks maskable", int'(take_o), 0);
    ret_now();
    chk(nmi_active_o == 0 && active_o == 8'h02, "R11 nmi return", int'(active_o), 2);
    tick();
    chk(take_o == 1 && take_nmi_o == 0 && take_id_o == 4, "R11 resume maskable",
        int'(take_id_o), 4);
    ack_now();
    ret_now();
    ret_now();
    nmi_i = 1'b0;
    tick();
    chk(active_o == 8'h00 && cur_idle_o == 1, "R9 unwound", int'(active_o), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule